// File: doc/BRIEF.md
# Colour Matrix Coefficient Loader

This block receives the nine coefficients of a 3x3 colour-transform matrix as a serial stream, one 64-bit word per cycle. Each word is sign-magnitude, with a 32-bit integer part and a 32-bit fraction. The block converts each word to a 15-bit two's-complement fixed-point value with 3 integer bits and 12 fraction bits. It also checks whether that value can represent the input. The matrix datapath downstream reads the nine results from a parallel coefficient bank.

A load begins with a start strobe. Each beat then carries a coefficient and a slot index. The bank changes only when all nine coefficients of a load are representable. If any one of them overflows, the whole set is dropped and the bank keeps the previous matrix. A one-cycle pulse reports the outcome: done when the bank was updated, error when the set was rejected. A new start strobe issued part-way through a load abandons that load without touching the bank.

Top module: `ccm_coef_loader`

## Requirements
- R1: For an input with bit 63 clear, the converted value is input bits [34:20]. All bits above 34 and below 20 are dropped.
- R2: For an input with bit 63 set, the converted value is the 15-bit two's complement of input bits [34:20]. For example, -1.0 (magnitude 0x1000) gives 0x7000.
- R3: A coefficient overflows when its sign bit (63) differs from bit 14 of its converted value. The check is made after negation, so a negative input with magnitude 0x2000 is accepted as 0x6000. A positive input with magnitude 0x4000 is rejected.
- R4: A negative input whose 15-bit magnitude is zero converts to 0 and is accepted.
- R5: A load starts on seq_start. Each beat with coef_valid high and coef_idx in 0..8 writes converted slot coef_idx and counts toward the load. Indices within one load are expected to be distinct. On the ninth counted beat, if no coefficient of the load overflowed, the whole bank is written at the next clock edge and load_done is high for exactly that one cycle. Slot k occupies coef_bank bits [15k+14:15k].
- R6: If any coefficient of the load overflowed, coef_bank is unchanged and load_err pulses for one cycle in place of load_done.
- R7: A seq_start before the ninth counted beat abandons the running load. No bank write and no pulse result from it, and counting restarts from zero.
- R8: A beat that has seq_start and coef_valid high together is the first counted beat of the new load. This also holds when it would have been the ninth beat of the old load.
- R9: Beats with coef_valid high are ignored when no load is active, and also when coef_idx is 9 or more. Ignored beats are not counted and do not affect overflow.
- R10: After reset, coef_bank is all zero, load_done and load_err are low, and no load is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_start | input | 1 | Begins a new coefficient load |
| coef_valid | input | 1 | Coefficient beat present |
| coef_idx | input | 4 | Slot index of the beat (0..8) |
| coef_in | input | 64 | Sign-magnitude coefficient, 32.32 format |
| load_done | output | 1 | One-cycle pulse: bank updated |
| load_err | output | 1 | One-cycle pulse: set rejected |
| coef_bank | output | 135 | Nine 15-bit two's-complement coefficients, slot k at [15k+14:15k] |

## Verification
Completing a load and starting a new one can both occur in the same cycle. The bench provokes this by raising seq_start together with coef_valid on what would be the ninth beat of a load. It then checks that no pulse appears and the bank stays unchanged in the following cycle. Eight further beats must then complete the new load, with the coincident beat's value in slot 0. Abandoning a load that already holds an overflowed coefficient is judged the same way. The following clean load must end in done, not error.

// File: rtl/ccm_pkg.sv
// Shared sizing for the colour matrix coefficient loader.
// Assumes the fraction drop plus result width stays below the sign bit.
package ccm_pkg;
    localparam int NUM_COEF  = 9;
    localparam int IN_W      = 64;
    localparam int Q_W       = 15;
    localparam int FRAC_DROP = 20;
    localparam int IDX_W     = 4;
endpackage

// File: rtl/ccm_coef_conv.sv
// Converts one sign-magnitude fixed-point word to a Q_W-bit two's-complement
// value and flags overflow. Purely combinational.
// Assumes FRAC_DROP + Q_W <= IN_W - 1 (the magnitude field excludes the sign).
module ccm_coef_conv #(
    parameter int IN_W      = 64,
    parameter int Q_W       = 15,
    parameter int FRAC_DROP = 20
) (
    input  logic [IN_W-1:0] din,
    output logic [Q_W-1:0]  q_val,
    output logic            q_bad
);
    logic           sgn;
    logic [Q_W-1:0] mag;
    logic [Q_W-1:0] neg;

    // Select magnitude bits, negate for negative inputs, then test the range
    always_comb begin
        sgn   = din[IN_W-1];
        mag   = din[FRAC_DROP +: Q_W];
        neg   = ~mag + 1'b1;
        q_val = sgn ? neg : mag;
        q_bad = (sgn != q_val[Q_W-1]) && !(sgn && (mag == '0));
    end
endmodule

// File: rtl/ccm_seq_ctrl.sv
// Load sequencer: counts accepted beats, keeps a sticky overflow flag and
// emits the registered done / error pulses.
// Assumes seq_start takes priority over completion of a running load.
module ccm_seq_ctrl #(
    parameter int NUM_COEF = 9,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_start,
    input  logic             coef_valid,
    input  logic [IDX_W-1:0] coef_idx,
    input  logic             beat_bad,
    output logic             accept,
    output logic             commit_ok,
    output logic             load_done,
    output logic             load_err
);
    localparam int CNT_W = $clog2(NUM_COEF + 1);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             err_sticky;
    logic [CNT_W-1:0] cnt_base;
    logic             err_base;
    logic             last_beat;
    logic             bad_all;

    // Decide whether this beat belongs to a load and whether it finishes it
    always_comb begin
        accept    = coef_valid && (int'(coef_idx) < NUM_COEF) && (active || seq_start);
        cnt_base  = seq_start ? '0 : cnt;
        err_base  = seq_start ? 1'b0 : err_sticky;
        last_beat = accept && (cnt_base == CNT_W'(NUM_COEF - 1));
        bad_all   = err_base || (accept && beat_bad);
        commit_ok = last_beat && !bad_all;
    end

    // Sequence state and outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            cnt        <= '0;
            err_sticky <= 1'b0;
            load_done  <= 1'b0;
            load_err   <= 1'b0;
        end else begin
            load_done <= last_beat && !bad_all;
            load_err  <= last_beat && bad_all;
            if (last_beat) begin
                active     <= 1'b0;
                cnt        <= '0;
                err_sticky <= 1'b0;
            end else if (seq_start || active) begin
                active     <= 1'b1;
                cnt        <= accept ? cnt_base + 1'b1 : cnt_base;
                err_sticky <= bad_all;
            end
        end
    end
endmodule

// File: rtl/ccm_stage.sv
// Staging registers, one per matrix slot, written by accepted beats.
// Exposes a merged next-state view so the bank can commit the ninth beat
// in the same edge. Assumes distinct slot indices within one load.
module ccm_stage #(
    parameter int NUM_COEF = 9,
    parameter int Q_W      = 15,
    parameter int IDX_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic [IDX_W-1:0]        coef_idx,
    input  logic [Q_W-1:0]          q_val,
    output logic [NUM_COEF*Q_W-1:0] stage_nxt
);
    for (genvar k = 0; k < NUM_COEF; k++) begin : g_slot
        logic [Q_W-1:0] slot_q;
        logic           wr;

        // Slot write enable and merged view of this slot
        always_comb begin
            wr = accept && (coef_idx == IDX_W'(k));
            stage_nxt[k*Q_W +: Q_W] = wr ? q_val : slot_q;
        end

        // Slot storage
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= stage_nxt[k*Q_W +: Q_W];
        end
    end
endmodule

// File: rtl/ccm_coef_loader.sv
// Top level: serial coefficient converter with an all-or-nothing bank.
// Assumes one coefficient per beat; the bank changes only on load_done.
module ccm_coef_loader
    import ccm_pkg::*;
#(
    parameter int N_COEF = NUM_COEF,
    parameter int DIN_W  = IN_W,
    parameter int QV_W   = Q_W,
    parameter int DROP   = FRAC_DROP,
    parameter int IX_W   = IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  seq_start,
    input  logic                  coef_valid,
    input  logic [IX_W-1:0]       coef_idx,
    input  logic [DIN_W-1:0]      coef_in,
    output logic                  load_done,
    output logic                  load_err,
    output logic [N_COEF*QV_W-1:0] coef_bank
);
    localparam int BANK_W = N_COEF * QV_W;

    logic [QV_W-1:0]   q_val;
    logic              q_bad;
    logic              accept;
    logic              commit_ok;
    logic [BANK_W-1:0] stage_nxt;

    ccm_coef_conv #(.IN_W(DIN_W), .Q_W(QV_W), .FRAC_DROP(DROP)) u_conv (
        .din   (coef_in),
        .q_val (q_val),
        .q_bad (q_bad)
    );

    ccm_seq_ctrl #(.NUM_COEF(N_COEF), .IDX_W(IX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_start  (seq_start),
        .coef_valid (coef_valid),
        .coef_idx   (coef_idx),
        .beat_bad   (q_bad),
        .accept     (accept),
        .commit_ok  (commit_ok),
        .load_done  (load_done),
        .load_err   (load_err)
    );

    ccm_stage #(.NUM_COEF(N_COEF), .Q_W(QV_W), .IDX_W(IX_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .coef_idx  (coef_idx),
        .q_val     (q_val),
        .stage_nxt (stage_nxt)
    );

    // Coefficient bank: whole-set commit on a clean ninth beat
    always_ff @(posedge clk) begin
        if (!rst_n)         coef_bank <= '0;
        else if (commit_ok) coef_bank <= stage_nxt;
    end
endmodule

// File: rtl/ccm_coef_loader_chk.sv
// Temporal checks on the loader's ports, bound into every instance.
module ccm_coef_loader_chk #(
    parameter int BANK_W = 135
) (
    input logic              clk,
    input logic              rst_n,
    input logic              coef_valid,
    input logic              load_done,
    input logic              load_err,
    input logic [BANK_W-1:0] coef_bank
);
    // R6
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && load_err));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(coef_bank) |-> load_done);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);

    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> !load_err);

    // R5
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> $past(coef_valid));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_err) |-> $past(coef_valid));
endmodule

bind ccm_coef_loader ccm_coef_loader_chk #(.BANK_W(N_COEF * QV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_valid (coef_valid),
    .load_done  (load_done),
    .load_err   (load_err),
    .coef_bank  (coef_bank)
);

// File: tb/ccm_coef_loader_bench.sv
`timescale 1ns/1ps
module ccm_coef_loader_bench;
    localparam int N  = 9;
    localparam int QW = 15;
    localparam int BW = N * QW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seq_start = 1'b0;
    logic          coef_valid = 1'b0;
    logic [3:0]    coef_idx = '0;
    logic [63:0]   coef_in = '0;
    logic          load_done;
    logic          load_err;
    logic [BW-1:0] coef_bank;

    int n_tests = 0;
    int n_fail  = 0;
    logic [BW-1:0] model_bank = '0;

    always #4 clk = ~clk;

    ccm_coef_loader u_ccm_coef_loader (
        .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .coef_valid(coef_valid),
        .coef_idx(coef_idx), .coef_in(coef_in), .load_done(load_done),
        .load_err(load_err), .coef_bank(coef_bank)
    );

    // {input word, expected 15-bit value, accepted}
    localparam logic [79:0] VEC [12] = '{
        {64'h0000_0001_0000_0000, 15'h1000, 1'b1}, // R1 +1.0
        {64'h8000_0001_0000_0000, 15'h7000, 1'b1}, // R2 -1.0
        {64'h8000_0002_0000_0000, 15'h6000, 1'b1}, // R3 -2.0 accepted
        {64'h8000_0004_0000_0000, 15'h4000, 1'b1}, // R3 -4.0 accepted
        {64'h0000_0004_0000_0000, 15'h0000, 1'b0}, // R3 +4.0 rejected
        {64'h0000_0003_FFF0_0000, 15'h3FFF, 1'b1}, // R1 largest positive
        {64'h8000_0000_0000_0000, 15'h0000, 1'b1}, // R4 negative zero
        {64'h8000_0004_0010_0000, 15'h0000, 1'b0}, // R3 below range
        {64'h0000_0000_000F_FFFF, 15'h0000, 1'b1}, // R1 fraction dropped
        {64'h0000_0008_0000_0000, 15'h0000, 1'b1}, // R1 high bits dropped
        {64'h8000_0000_0010_0000, 15'h7FFF, 1'b1}, // R2 smallest negative
        {64'h0000_0007_0000_0000, 15'h0000, 1'b0}  // R3 positive overflow
    };

    task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic beat(input logic st, input logic vl, input logic [3:0] ix, input logic [63:0] d);
        @(negedge clk);
        seq_start = st; coef_valid = vl; coef_idx = ix; coef_in = d;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        seq_start = 1'b0; coef_valid = 1'b0; coef_idx = '0; coef_in = '0;
    endtask

    function automatic logic [63:0] filler(input int k, input int off);
        return 64'(k + off) << 28;
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 bank", coef_bank, '0);
        chk("R10 pulses", BW'({load_done, load_err}), '0);
        rst_n = 1'b1;

        // Vector walk: table word in slot i%9, fillers elsewhere
        for (int i = 0; i < 12; i++) begin
            logic [63:0] w;
            logic [14:0] ev;
            logic        ok;
            int          s;
            w = VEC[i][79:16]; ev = VEC[i][15:1]; ok = VEC[i][0]; s = i % N;
            beat(1'b1, 1'b0, '0, '0);
            for (int k = 0; k < N; k++)
                beat(1'b0, 1'b1, 4'(k), (k == s) ? w : filler(k, i));
            idle();
            if (ok) begin
                for (int k = 0; k < N; k++)
                    model_bank[k*QW +: QW] = (k == s) ? ev : 15'((k + i) << 8);
                chk("R5 done pulse", BW'({load_done, load_err}), BW'(2'b10));
            end else begin
                chk("R6 err pulse", BW'({load_done, load_err}), BW'(2'b01));
            end
            chk("R1 R2 R3 R4 bank", coef_bank, model_bank);
            @(negedge clk);
            chk("R5 pulse width", BW'({load_done, load_err}), '0);
        end

        // R7: abort a load holding an overflow, then a clean load
        beat(1'b1, 1'b1, 4'd0, 64'h0000_0004_0000_0000);
        for (int k = 1; k < 5; k++) beat(1'b0, 1'b1, 4'(k), filler(k, 1));
        beat(1'b1, 1'b0, '0, '0);
        idle();
        chk("R7 no pulse on abort", BW'({load_done, load_err}), '0);
        chk("R7 bank kept", coef_bank, model_bank);
        for (int k = 0; k < N; k++) beat(1'b0, 1'b1, 4'(k), filler(k, 1));
        idle();
        for (int k = 0; k < N; k++) model_bank[k*QW +: QW] = 15'((k + 1) << 8);
        chk("R7 clean load done", BW'({load_done, load_err}), BW'(2'b10));
        chk("R7 bank", coef_bank, model_bank);

        // R8: start coincides with what would be the ninth beat
        beat(1'b1, 1'b0, '0, '0);
        for (int k = 0; k < N - 1; k++) beat(1'b0, 1'b1, 4'(k), filler(k, 2));
        beat(1'b1, 1'b1, 4'd0, 64'h0000_0001_0000_0000);
        idle();
        chk("R8 no pulse", BW'({load_done, load_err}), '0);
        chk("R8 bank kept", coef_bank, model_bank);
        for (int k = 1; k < N; k++) beat(1'b0, 1'b1, 4'(k), filler(k, 3));
        idle();
        for (int k = 0; k < N; k++) model_bank[k*QW +: QW] = (k == 0) ? 15'h1000 : 15'((k + 3) << 8);
        chk("R8 new load done", BW'({load_done, load_err}), BW'(2'b10));
        chk("R8 bank", coef_bank, model_bank);

        // R9: stray beats outside a load, and out-of-range indices inside one
        beat(1'b0, 1'b1, 4'd3, 64'h0000_0004_0000_0000);
        idle();
        chk("R9 idle beat ignored", BW'({load_done, load_err}), '0);
        chk("R9 idle bank", coef_bank, model_bank);
        beat(1'b1, 1'b0, '0, '0);
        for (int k = 0; k < N - 1; k++) begin
            beat(1'b0, 1'b1, 4'(k), filler(k, 4));
            beat(1'b0, 1'b1, 4'(9 + (k % 7)), 64'h0000_0007_0000_0000);
        end
        idle();
        chk("R9 bad idx not counted", BW'({load_done, load_err}), '0);
        beat(1'b0, 1'b1, 4'd8, filler(8, 4));
        idle();
        for (int k = 0; k < N; k++) model_bank[k*QW +: QW] = 15'((k + 4) << 8);
        chk("R9 load done", BW'({load_done, load_err}), BW'(2'b10));
        chk("R9 bank", coef_bank, model_bank);

        finish_run();
    end
endmodule